// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small synchronous SRAM. It accepts a new read or write command on every clock, so reads and writes can follow one another in any order with no idle cycles. A command and its address are registered on a rising edge. The data for a write is taken on the following enabled edge. Read data flows out combinationally during the cycle after the read command is registered.

A clock enable can stall the whole block. Bursts of up to four words step from a loaded address in either linear or interleaved order. Three chip enables select the device. A sleep input forces it idle while keeping the stored words. The output drivers turn off during the data phase of every write, and an asynchronous output enable also controls them.

The external bidirectional data bus is split into three ports: `dq_in`, `dq_out` and a drive enable `dq_oe`. Storage is a small array of 36-bit words, each made of four 9-bit byte lanes.

Top module: `flowsram_top`

## Requirements
- R1: On an edge with `clk_en`=1, `sleep`=0, `adv_ld`=0 and all chip enables active (`cs1_n`=0, `cs2`=1, `cs3_n`=0), a command is registered at `addr`. It is a write when `wr_en`=1 and a read when `wr_en`=0.
- R2: When `clk_en`=0, the rising edge has no effect. The registered command, burst position, stored words and `dq_out` hold, and a pending write data phase waits for the next enabled edge.
- R3: Write data is taken from `dq_in` on the enabled edge after the write command. Only lanes whose `byte_sel` bit, sampled with the command, is 1 are updated. Bit i selects data bits 9i+8 down to 9i.
- R4: A load edge with any chip enable inactive registers a deselect. `dq_oe` is then 0, and advance edges keep the block deselected.
- R5: `oe_n`=1 forces `dq_oe` to 0 in the same cycle, with no clock edge in the path.
- R6: `dq_oe` is 0 in every cycle whose registered command is a write, whatever the level of `oe_n`.
- R7: In the cycle after a read is registered, `dq_out` shows the addressed word and `dq_oe`=1 when `oe_n`=0. A read right after a write returns the newly written data, and a write right after a read needs no idle cycle.
- R8: An enabled edge with `adv_ld`=1 after a read or write moves to the next burst word. For step n (0 to 3, wrapping), the low two address bits are base+n modulo 4 when `burst_il` was 0 at load, and base XOR n when it was 1. The upper address bits are kept.
- R9: `sleep`=1 forces `dq_oe` to 0 at once. Enabled edges with `sleep`=1 register a deselect, and stored words are kept.
- R10: A synchronous active-high `rst` registers a deselect, so `dq_oe` is 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; 0 stalls the block |
| addr | input | 6 | Word address for a load |
| wr_en | input | 1 | 1 = write, 0 = read on a load |
| byte_sel | input | 4 | Per-lane write select |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new command |
| burst_il | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| sleep | input | 1 | Power-down request |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data bus |
| dq_out | output | 36 | Read data bus |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions check every cycle that a write data phase, a high `oe_n` or a deselect keeps the drivers off. They also check that a stalled edge freezes the command, the burst position and the read data, that the burst position steps by one on each advance, and that a load registers the right command and address. Only the bench scenarios can show the content of the data: byte-lane merging, burst address order in both modes, read-after-write coherence, a write postponed across a stall, and words preserved through sleep. These are checked against a reference memory kept in the bench.

// File: rtl/flowsram_pkg.sv
package flowsram_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;

  localparam int STEP_W = 2;

  // Low address bits of burst step 'step' from start 'start'
  function automatic logic [STEP_W-1:0] burst_low(
    input logic [STEP_W-1:0] start,
    input logic [STEP_W-1:0] step,
    input logic              il
  );
    return il ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/flowsram_ctl.sv
module flowsram_ctl
  import flowsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clk_en,
  input  logic                  sleep,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic [LANES-1:0]      byte_sel,
  input  logic                  cs1_n,
  input  logic                  cs2,
  input  logic                  cs3_n,
  input  logic                  adv_ld,
  input  logic                  burst_il,
  output cmd_e                  cmd_q,
  output logic [ADDR_W-1:0]     base_q,
  output logic [STEP_W-1:0]     cnt_q,
  output logic                  il_q,
  output logic [LANES-1:0]      bsel_q
);

  logic sel_all;
  assign sel_all = !cs1_n && cs2 && !cs3_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      il_q   <= 1'b0;
      bsel_q <= '0;
    end else if (clk_en) begin
      if (sleep) begin
        cmd_q <= CMD_IDLE;
      end else if (!adv_ld) begin
        if (sel_all) begin
          cmd_q  <= wr_en ? CMD_WR : CMD_RD;
          base_q <= addr;
          cnt_q  <= '0;
          il_q   <= burst_il;
          bsel_q <= byte_sel;
        end else begin
          cmd_q <= CMD_IDLE;
        end
      end else if (cmd_q != CMD_IDLE) begin
        cnt_q  <= cnt_q + 2'd1;
        bsel_q <= byte_sel;
      end
    end
  end

  // R1: a selected write load registers a write at the given address
  a_r1_load_write: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sleep && !adv_ld && !cs1_n && cs2 && !cs3_n && wr_en)
      |=> (cmd_q == CMD_WR && base_q == $past(addr)));

  // R1: a selected read load registers a read
  a_r1_load_read: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sleep && !adv_ld && !cs1_n && cs2 && !cs3_n && !wr_en)
      |=> (cmd_q == CMD_RD));

  // R2: stalled edge freezes command and burst position
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (!clk_en) |=> ($stable(cmd_q) && $stable(cnt_q) && $stable(base_q)));

  // R4: a load with any chip enable inactive deselects
  a_r4_desel_load: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sleep && !adv_ld && (cs1_n || !cs2 || cs3_n))
      |=> (cmd_q == CMD_IDLE));

  // R8: each advance steps the burst position by one
  a_r8_burst_step: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sleep && adv_ld && cmd_q != CMD_IDLE)
      |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R9: sleep on an enabled edge deselects
  a_r9_sleep_idle: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sleep) |=> (cmd_q == CMD_IDLE));

endmodule

// File: rtl/flowsram_burst.sv
module flowsram_burst
  import flowsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [STEP_W-1:0] step,
  input  logic              il,
  output logic [ADDR_W-1:0] eff
);

  localparam int HI = ADDR_W - 1;

  always_comb begin
    eff = {base[HI:STEP_W], burst_low(base[STEP_W-1:0], step, il)};
  end

endmodule

// File: rtl/flowsram_array.sv
module flowsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      wr_go,
  input  logic [LANES-1:0]          lane_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_go && lane_en[g]) begin
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end

endmodule

// File: rtl/flowsram_top.sv
module flowsram_top
  import flowsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clk_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [LANES-1:0]         byte_sel,
  input  logic                     cs1_n,
  input  logic                     cs2,
  input  logic                     cs3_n,
  input  logic                     adv_ld,
  input  logic                     burst_il,
  input  logic                     sleep,
  input  logic                     oe_n,
  input  logic [LANES*LANE_W-1:0]  dq_in,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic                     dq_oe
);

  localparam int DW = LANES * LANE_W;

  cmd_e              cmd_q;
  logic [ADDR_W-1:0] base_q;
  logic [STEP_W-1:0] cnt_q;
  logic              il_q;
  logic [LANES-1:0]  bsel_q;
  logic [ADDR_W-1:0] eff_addr;
  logic [DW-1:0]     rd_word;
  logic              wr_go;

  flowsram_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .sleep    (sleep),
    .addr     (addr),
    .wr_en    (wr_en),
    .byte_sel (byte_sel),
    .cs1_n    (cs1_n),
    .cs2      (cs2),
    .cs3_n    (cs3_n),
    .adv_ld   (adv_ld),
    .burst_il (burst_il),
    .cmd_q    (cmd_q),
    .base_q   (base_q),
    .cnt_q    (cnt_q),
    .il_q     (il_q),
    .bsel_q   (bsel_q)
  );

  flowsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .base (base_q),
    .step (cnt_q),
    .il   (il_q),
    .eff  (eff_addr)
  );

  // Data phase of a registered write completes on the next enabled edge
  assign wr_go = clk_en && !rst && (cmd_q == CMD_WR);

  flowsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .wr_go   (wr_go),
    .lane_en (bsel_q),
    .addr    (eff_addr),
    .wdata   (dq_in),
    .rdata   (rd_word)
  );

  // Flow-through read path; drivers gated asynchronously
  assign dq_out = rd_word;
  assign dq_oe  = !oe_n && !sleep && (cmd_q == CMD_RD);

  // R5: output enable high keeps drivers off
  a_r5_oe_off: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);

  // R6: drivers off during a write data phase
  a_r6_wr_quiet: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_WR) |-> !dq_oe);

  // R9: sleep keeps drivers off
  a_r9_sleep_off: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dq_oe);

  // R2: stalled edge holds the read data
  a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
    (!clk_en) |=> $stable(dq_out));

endmodule

// File: tb/sim_flowsram_top.sv
module sim_flowsram_top;

  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, clk_en, wr_en, cs1_n, cs2, cs3_n, adv_ld, burst_il, sleep, oe_n;
  logic [AW-1:0] addr;
  logic [NL-1:0] byte_sel;
  logic [DW-1:0] dq_in, dq_out;
  logic dq_oe;

  always #2.5 clk = ~clk;

  flowsram_top #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr), .wr_en(wr_en),
    .byte_sel(byte_sel), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .adv_ld(adv_ld), .burst_il(burst_il), .sleep(sleep), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state built from the requirements
  logic [DW-1:0] ref_mem [DEPTH];
  int            m_cmd;      // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_il;
  logic [NL-1:0] m_bsel;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = m_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] pat(input int a);
    return 36'h5_A5A5_0000 | DW'(a * 37);
  endfunction

  task automatic tick();
    if (rst) begin
      m_cmd = 0; m_cnt = 0; m_base = 0; m_il = 0; m_bsel = 0;
    end else if (clk_en) begin
      if (m_cmd == 2) begin
        for (int l = 0; l < NL; l++)
          if (m_bsel[l]) ref_mem[m_addr()][l*LW +: LW] = dq_in[l*LW +: LW];
      end
      if (sleep) m_cmd = 0;
      else if (!adv_ld) begin
        if (!cs1_n && cs2 && !cs3_n) begin
          m_cmd = wr_en ? 2 : 1; m_base = addr; m_cnt = 0;
          m_il = burst_il; m_bsel = byte_sel;
        end else m_cmd = 0;
      end else if (m_cmd != 0) begin
        m_cnt = m_cnt + 2'd1; m_bsel = byte_sel;
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag);
    logic exp_oe;
    exp_oe = !oe_n && !sleep && (m_cmd == 1);
    n_run++;
    if (dq_oe !== exp_oe) begin
      n_fail++;
      $display("FAIL %s dq_oe actual %b expected %b", tag, dq_oe, exp_oe);
    end else if (exp_oe && dq_out !== ref_mem[m_addr()]) begin
      n_fail++;
      $display("FAIL %s dq_out actual %h expected %h", tag, dq_out, ref_mem[m_addr()]);
    end
  endtask

  task automatic chk_val(input string tag, input logic [DW-1:0] exp);
    n_run++;
    if (dq_oe !== 1'b1 || dq_out !== exp) begin
      n_fail++;
      $display("FAIL %s oe/data actual %b/%h expected 1/%h", tag, dq_oe, dq_out, exp);
    end
  endtask

  task automatic chk_off(input string tag);
    n_run++;
    if (dq_oe !== 1'b0) begin
      n_fail++;
      $display("FAIL %s dq_oe actual %b expected 0", tag, dq_oe);
    end
  endtask

  task automatic op_load(input logic wr, input int a, input logic [NL-1:0] bs,
                         input logic il, input logic [DW-1:0] d);
    clk_en = 1; adv_ld = 0; cs1_n = 0; cs2 = 1; cs3_n = 0;
    wr_en = wr; addr = AW'(a); byte_sel = bs; burst_il = il; dq_in = d;
    tick();
  endtask

  task automatic op_adv(input logic [NL-1:0] bs, input logic [DW-1:0] d);
    clk_en = 1; adv_ld = 1; byte_sel = bs; dq_in = d;
    tick();
  endtask

  task automatic op_nop(input logic [DW-1:0] d);
    clk_en = 1; adv_ld = 0; cs1_n = 1; cs2 = 1; cs3_n = 0; dq_in = d;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; clk_en = 0; wr_en = 0; cs1_n = 1; cs2 = 0; cs3_n = 1;
    adv_ld = 0; burst_il = 0; sleep = 0; oe_n = 0; addr = 0; byte_sel = 0; dq_in = 0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    m_cmd = 0; m_base = 0; m_cnt = 0; m_il = 0; m_bsel = 0;
    #1;
    tick(); tick();
    chk_off("R10");
    rst = 0;

    // Fill all words with linear write bursts (R1, R3, R8)
    for (int i = 0; i <= DEPTH; i++) begin
      logic [DW-1:0] d;
      d = (i > 0) ? pat(i - 1) : '0;
      if (i == DEPTH) op_nop(d);
      else if (i % 4 == 0) op_load(1, i, 4'hF, 0, d);
      else op_adv(4'hF, d);
      if (i < DEPTH) chk_off("R6");
    end

    // Linear burst read from low bits 2 (R8)
    op_load(0, 10, 4'h0, 0, '0); chk_val("R8", pat(10));
    op_adv(4'h0, '0); chk_val("R8", pat(11));
    op_adv(4'h0, '0); chk_val("R8", pat(8));
    op_adv(4'h0, '0); chk_val("R8", pat(9));
    op_adv(4'h0, '0); chk_val("R8", pat(10));
    // Interleaved from low bits 3 and 1 (R8)
    op_load(0, 7, 4'h0, 1, '0); chk_val("R8", pat(7));
    op_adv(4'h0, '0); chk_val("R8", pat(6));
    op_adv(4'h0, '0); chk_val("R8", pat(5));
    op_adv(4'h0, '0); chk_val("R8", pat(4));
    op_load(0, 37, 4'h0, 1, '0); chk_val("R8", pat(37));
    op_adv(4'h0, '0); chk_val("R8", pat(36));
    op_adv(4'h0, '0); chk_val("R8", pat(39));
    op_adv(4'h0, '0); chk_val("R8", pat(38));

    // Partial byte write then immediate read (R3, R7)
    op_load(1, 20, 4'b0101, 0, '0); chk_off("R6");
    op_load(0, 20, 4'h0, 0, {DW{1'b1}});
    chk_val("R3", (pat(20) & ~36'h0_07FC_01FF) | 36'h0_07FC_01FF);
    chk("R1");

    // Write right after read, then read it back (R7)
    op_load(0, 30, 4'h0, 0, '0); chk_val("R7", pat(30));
    op_load(1, 31, 4'hF, 0, '0); chk_off("R6");
    op_load(0, 31, 4'h0, 0, 36'h1_2345_6789); chk_val("R7", 36'h1_2345_6789);

    // Asynchronous output enable (R5)
    oe_n = 1;
    op_load(0, 12, 4'h0, 0, '0); chk_off("R5");
    oe_n = 0; #1; chk_val("R5", pat(12));
    oe_n = 1; #0.5; chk_off("R5");
    oe_n = 0;

    // Each chip enable inactive in turn (R4)
    op_load(0, 13, 4'h0, 0, '0);
    cs1_n = 1; cs2 = 1; cs3_n = 0; clk_en = 1; adv_ld = 0; tick(); chk_off("R4");
    op_load(0, 13, 4'h0, 0, '0); chk_val("R4", pat(13));
    cs1_n = 0; cs2 = 0; cs3_n = 0; adv_ld = 0; tick(); chk_off("R4");
    op_adv(4'h0, '0); chk_off("R4");
    op_load(0, 13, 4'h0, 0, '0);
    cs1_n = 0; cs2 = 1; cs3_n = 1; adv_ld = 0; tick(); chk_off("R4");

    // Clock enable stall (R2)
    op_load(0, 40, 4'h0, 0, '0); chk_val("R2", pat(40));
    for (int k = 0; k < 3; k++) begin
      clk_en = 0; adv_ld = 0; addr = 41; cs1_n = 0; cs2 = 1; cs3_n = 0; wr_en = 1;
      tick(); chk_val("R2", pat(40));
    end
    op_load(1, 42, 4'hF, 0, '0);
    for (int k = 0; k < 2; k++) begin
      clk_en = 0; dq_in = 36'hF_0F0F_0F0F; tick(); chk_off("R2");
    end
    op_load(0, 42, 4'h0, 0, 36'h2_2222_2222); chk_val("R2", 36'h2_2222_2222);

    // Sleep (R9)
    op_load(0, 44, 4'h0, 0, '0); chk_val("R9", pat(44));
    sleep = 1; #1; chk_off("R9");
    op_load(1, 44, 4'hF, 0, '0); chk_off("R9");
    sleep = 0; op_adv(4'hF, 36'h3_3333_3333); chk_off("R9");
    op_load(0, 44, 4'h0, 0, '0); chk_val("R9", pat(44));

    // Reset mid-read (R10)
    op_load(0, 45, 4'h0, 0, '0);
    rst = 1; tick(); chk_off("R10"); rst = 0;

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      clk_en   = ($urandom_range(0, 9) != 0);
      adv_ld   = ($urandom_range(0, 9) < 4);
      wr_en    = $urandom_range(0, 1) == 1;
      cs1_n    = ($urandom_range(0, 15) == 0);
      cs2      = ($urandom_range(0, 15) != 0);
      cs3_n    = ($urandom_range(0, 15) == 0);
      burst_il = $urandom_range(0, 1) == 1;
      sleep    = ($urandom_range(0, 31) == 0);
      oe_n     = ($urandom_range(0, 9) == 0);
      addr     = AW'($urandom_range(0, DEPTH - 1));
      byte_sel = NL'($urandom_range(0, 15));
      dq_in    = {4'($urandom), 32'($urandom)};
      tick();
      chk("R7");
    end

    finish_run();
  end

endmodule